// File: doc/BRIEF.md
# Direct-Mapped Write-Back Cache with Victim Buffer

This block is a byte-addressed data cache for a processor. Its main store is direct-mapped: each memory block has exactly one home line, chosen by the index bits of the address. The cache is write-back, so stores stay in the cache and mark the line dirty. Memory sees a line only when that line finally leaves the cache and is dirty.

A small fully associative victim buffer sits beside the main store. A line pushed out of its home slot by a conflicting block goes into this buffer instead of being dropped. When the main store misses, the buffer is searched next. On a hit there, the buffered line and the current home line trade places, with their dirty bits, and memory is not used. Only a miss in both structures fetches a block from memory. The buffer replaces entries in arrival order, and a dirty entry is written to memory before its slot is reused.

The processor side has a valid/ready request channel and a response pulse. A request is taken on a cycle where `cpu_req_valid` and `cpu_req_ready` are both high. Its fields must stay stable while valid is high and ready is low. Only one request is in flight at a time: ready stays low until that request's response has been given. The response is a one-cycle pulse on `cpu_rsp_valid` and cannot be back-pressured.

The memory side has a request channel carrying a block number, a write flag and a full block of data. The cache holds that request unchanged until `mem_req_ready` is seen. A read is answered later by a one-cycle `mem_rsp_valid` pulse carrying the block. The cache has at most one memory transaction open at a time and accepts `mem_rsp_valid` only while a read is outstanding.

Top module: `vc_cache`

## Requirements
- R1: The address splits, from most to least significant, into tag, index and byte offset. With the defaults (24-bit address, 6 index bits, 2 offset bits) the tag is bits 23:8, the index is bits 7:2 and the offset is bits 1:0. A block is 32 bits, and offset k selects block bits 8k+7:8k. The memory block number is address bits 23:2.
- R2: After reset every main line and every victim entry is invalid, `cpu_req_ready` is high and no memory request is driven. The first access to any address therefore fetches its block from memory.
- R3: A read that hits the main store returns the addressed byte with no memory transaction. The response comes only for a request that has been accepted.
- R4: A write that hits replaces only the addressed byte in the cache and marks the line dirty, with no memory transaction. Its response returns the written byte.
- R5: A miss in both structures issues one memory read (`mem_req_write`=0) for the block number. The block is then installed clean, and the request completes from it; a write completes as in R4.
- R6: A valid line displaced from the main store goes into the victim buffer. A later access to that block swaps it back with the current home line, with no memory read. A block is never held in more than one victim entry.
- R7: The victim buffer replaces its entries oldest first. A displaced victim entry that is dirty is written to memory (`mem_req_write`=1, its block number and data) before the read for the new block. A clean or empty one causes no memory write. At most one memory transaction is open at a time.
- R8: Dirty bits move with swapped lines. A line written while in the main store, then swapped into and out of the buffer, is written back with the modified data when it finally leaves the buffer.
- R9: Back-pressure: `cpu_req_ready` is low from acceptance until the response. A memory request keeps its block number, write flag and data unchanged until `mem_req_ready`.
- R10: When two blocks with the same index are accessed alternately, only the first two accesses read memory.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can take a request |
| cpu_req_write | input | 1 | 1 = byte store, 0 = byte load |
| cpu_req_addr | input | ADDR_W | Byte address |
| cpu_req_wdata | input | 8 | Store byte |
| cpu_rsp_valid | output | 1 | One-cycle completion pulse |
| cpu_rsp_rdata | output | 8 | Loaded byte, or the stored byte for a write |
| mem_req_valid | output | 1 | Memory request present |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_write | output | 1 | 1 = write-back, 0 = block fetch |
| mem_req_blk | output | ADDR_W-OFF_W | Memory block number |
| mem_req_wdata | output | 8<<OFF_W | Write-back block data |
| mem_rsp_valid | input | 1 | Fetched block present (one cycle) |
| mem_rsp_rdata | input | 8<<OFF_W | Fetched block data |

## Verification
The main patterns are as follows. Repeated loads to one block separate hits from fetches. Byte stores followed by loads show lane placement and dirty marking. Two blocks that share an index, accessed alternately, must cost exactly two fetches, which shows that the swap path works. A run of further same-index blocks then walks the buffer's replacement pointer around. That run separates a dirty displacement, which must write back the stored byte, from clean or empty ones, which must not. Memory read and write counts are compared after each step, so a hidden extra fetch or write-back is caught even when the returned data is correct.

// File: rtl/vc_cache_pkg.sv
package vc_cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CMP,
    ST_WB,
    ST_RD_REQ,
    ST_RD_WAIT
  } cstate_e;
endpackage

// File: rtl/vc_line_store.sv
// Direct-mapped line storage: one combinational read port, one write port.
module vc_line_store #(
  parameter int IDX_W  = 6,
  parameter int TAG_W  = 16,
  parameter int LINE_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  idx,
  output logic              rd_valid,
  output logic              rd_dirty,
  output logic [TAG_W-1:0]  rd_tag,
  output logic [LINE_W-1:0] rd_data,
  input  logic              we,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [TAG_W-1:0]  wr_tag,
  input  logic [LINE_W-1:0] wr_data
);
  localparam int LINES = 1 << IDX_W;

  logic [LINES-1:0]  valid_q, dirty_q;
  logic [TAG_W-1:0]  tag_q  [LINES];
  logic [LINE_W-1:0] data_q [LINES];

  assign rd_valid = valid_q[idx];
  assign rd_dirty = dirty_q[idx];
  assign rd_tag   = tag_q[idx];
  assign rd_data  = data_q[idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (we) begin
      valid_q[idx] <= wr_valid;
      dirty_q[idx] <= wr_dirty;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      tag_q[idx]  <= wr_tag;
      data_q[idx] <= wr_data;
    end
  end
endmodule

// File: rtl/vc_victim_buf.sv
// Fully associative victim buffer with oldest-first slot pointer.
module vc_victim_buf #(
  parameter int ENTRIES = 4,
  parameter int BLK_W   = 22,
  parameter int LINE_W  = 32,
  localparam int PTR_W  = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BLK_W-1:0]  lk_blk,
  output logic [ENTRIES-1:0] match,
  output logic              hit,
  output logic [PTR_W-1:0]  hit_sel,
  output logic              hit_dirty,
  output logic [LINE_W-1:0] hit_data,
  output logic [PTR_W-1:0]  ptr,
  output logic              old_valid,
  output logic              old_dirty,
  output logic [BLK_W-1:0]  old_blk,
  output logic [LINE_W-1:0] old_data,
  input  logic              we,
  input  logic [PTR_W-1:0]  wr_sel,
  input  logic              wr_valid,
  input  logic              wr_dirty,
  input  logic [BLK_W-1:0]  wr_blk,
  input  logic [LINE_W-1:0] wr_data,
  input  logic              adv
);
  logic [ENTRIES-1:0] valid_q, dirty_q;
  logic [BLK_W-1:0]   blk_q  [ENTRIES];
  logic [LINE_W-1:0]  data_q [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match[g] = valid_q[g] && (blk_q[g] == lk_blk);
  end

  assign hit = |match;

  always_comb begin
    hit_sel = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (match[i]) hit_sel = PTR_W'(i);
  end

  assign hit_dirty = dirty_q[hit_sel];
  assign hit_data  = data_q[hit_sel];
  assign old_valid = valid_q[ptr];
  assign old_dirty = dirty_q[ptr];
  assign old_blk   = blk_q[ptr];
  assign old_data  = data_q[ptr];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid_q <= '0;
      dirty_q <= '0;
      ptr     <= '0;
    end else begin
      if (we) begin
        valid_q[wr_sel] <= wr_valid;
        dirty_q[wr_sel] <= wr_dirty;
      end
      if (adv) ptr <= (ptr == PTR_W'(ENTRIES - 1)) ? '0 : ptr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (we) begin
      blk_q[wr_sel]  <= wr_blk;
      data_q[wr_sel] <= wr_data;
    end
  end
endmodule

// File: rtl/vc_cache.sv
module vc_cache
  import vc_cache_pkg::*;
#(
  parameter int ADDR_W     = 24,
  parameter int IDX_W      = 6,
  parameter int OFF_W      = 2,
  parameter int VB_ENTRIES = 4,
  localparam int BLK_W     = ADDR_W - OFF_W,
  localparam int TAG_W     = BLK_W - IDX_W,
  localparam int LINE_W    = 8 << OFF_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req_valid,
  output logic              cpu_req_ready,
  input  logic              cpu_req_write,
  input  logic [ADDR_W-1:0] cpu_req_addr,
  input  logic [7:0]        cpu_req_wdata,
  output logic              cpu_rsp_valid,
  output logic [7:0]        cpu_rsp_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [BLK_W-1:0]  mem_req_blk,
  output logic [LINE_W-1:0] mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [LINE_W-1:0] mem_rsp_rdata
);
  localparam int PTR_W = $clog2(VB_ENTRIES);

  cstate_e           state, nstate;
  logic              r_write;
  logic [ADDR_W-1:0] r_addr;
  logic [7:0]        r_wdata;

  logic [TAG_W-1:0]  a_tag;
  logic [IDX_W-1:0]  a_idx;
  logic [OFF_W-1:0]  a_off;
  logic [BLK_W-1:0]  a_blk;
  assign a_blk = r_addr[ADDR_W-1:OFF_W];
  assign a_tag = r_addr[ADDR_W-1 -: TAG_W];
  assign a_idx = r_addr[OFF_W +: IDX_W];
  assign a_off = r_addr[OFF_W-1:0];

  // main store
  logic              m_valid, m_dirty, m_we, m_wvalid, m_wdirty;
  logic [TAG_W-1:0]  m_tag;
  logic [LINE_W-1:0] m_data, m_wdata, merged;

  vc_line_store #(.IDX_W(IDX_W), .TAG_W(TAG_W), .LINE_W(LINE_W)) u_main (
    .clk(clk), .rst_n(rst_n), .idx(a_idx),
    .rd_valid(m_valid), .rd_dirty(m_dirty), .rd_tag(m_tag), .rd_data(m_data),
    .we(m_we), .wr_valid(m_wvalid), .wr_dirty(m_wdirty), .wr_tag(a_tag),
    .wr_data(m_wdata)
  );

  // victim buffer
  logic [VB_ENTRIES-1:0] vb_match;
  logic              vb_hit, vb_hit_dirty, vb_old_valid, vb_old_dirty;
  logic              vb_we, vb_wvalid, vb_adv;
  logic [PTR_W-1:0]  vb_hit_sel, vb_ptr, vb_wsel;
  logic [LINE_W-1:0] vb_hit_data, vb_old_data;
  logic [BLK_W-1:0]  vb_old_blk;

  vc_victim_buf #(.ENTRIES(VB_ENTRIES), .BLK_W(BLK_W), .LINE_W(LINE_W)) u_vbuf (
    .clk(clk), .rst_n(rst_n), .lk_blk(a_blk), .match(vb_match),
    .hit(vb_hit), .hit_sel(vb_hit_sel), .hit_dirty(vb_hit_dirty),
    .hit_data(vb_hit_data), .ptr(vb_ptr), .old_valid(vb_old_valid),
    .old_dirty(vb_old_dirty), .old_blk(vb_old_blk), .old_data(vb_old_data),
    .we(vb_we), .wr_sel(vb_wsel), .wr_valid(vb_wvalid), .wr_dirty(m_dirty),
    .wr_blk({m_tag, a_idx}), .wr_data(m_data), .adv(vb_adv)
  );

  logic main_hit;
  assign main_hit = m_valid && (m_tag == a_tag);

  always_comb begin
    merged = m_data;
    merged[{a_off, 3'b000} +: 8] = r_wdata;
  end

  always_comb begin
    nstate        = state;
    cpu_req_ready = 1'b0;
    cpu_rsp_valid = 1'b0;
    cpu_rsp_rdata = r_write ? r_wdata : m_data[{a_off, 3'b000} +: 8];
    mem_req_valid = 1'b0;
    mem_req_write = 1'b0;
    mem_req_blk   = a_blk;
    mem_req_wdata = vb_old_data;
    m_we = 1'b0; m_wvalid = 1'b1; m_wdirty = 1'b0; m_wdata = merged;
    vb_we = 1'b0; vb_wsel = vb_ptr; vb_wvalid = m_valid; vb_adv = 1'b0;
    unique case (state)
      ST_IDLE: begin
        cpu_req_ready = 1'b1;
        if (cpu_req_valid) nstate = ST_CMP;
      end
      ST_CMP: begin
        if (main_hit) begin
          cpu_rsp_valid = 1'b1;
          m_we     = r_write;
          m_wdirty = 1'b1;
          nstate   = ST_IDLE;
        end else if (vb_hit) begin
          // swap home line and victim entry, dirty bits travel along
          m_we     = 1'b1;
          m_wdirty = vb_hit_dirty;
          m_wdata  = vb_hit_data;
          vb_we    = 1'b1;
          vb_wsel  = vb_hit_sel;
        end else if (m_valid && vb_old_valid && vb_old_dirty) begin
          nstate = ST_WB;
        end else begin
          vb_we  = m_valid;
          vb_adv = m_valid;
          nstate = ST_RD_REQ;
        end
      end
      ST_WB: begin
        mem_req_valid = 1'b1;
        mem_req_write = 1'b1;
        mem_req_blk   = vb_old_blk;
        if (mem_req_ready) begin
          vb_we  = 1'b1;
          vb_adv = 1'b1;
          nstate = ST_RD_REQ;
        end
      end
      ST_RD_REQ: begin
        mem_req_valid = 1'b1;
        if (mem_req_ready) nstate = ST_RD_WAIT;
      end
      ST_RD_WAIT: begin
        if (mem_rsp_valid) begin
          m_we    = 1'b1;
          m_wdata = mem_rsp_rdata;
          nstate  = ST_CMP;
        end
      end
      default: nstate = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      r_write <= 1'b0;
      r_addr  <= '0;
      r_wdata <= '0;
    end else begin
      state <= nstate;
      if (state == ST_IDLE && cpu_req_valid) begin
        r_write <= cpu_req_write;
        r_addr  <= cpu_req_addr;
        r_wdata <= cpu_req_wdata;
      end
    end
  end
endmodule

// File: rtl/vc_cache_chk.sv
module vc_cache_chk #(
  parameter int BLK_W      = 22,
  parameter int LINE_W     = 32,
  parameter int VB_ENTRIES = 4
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  cpu_req_valid,
  input logic                  cpu_req_ready,
  input logic                  cpu_rsp_valid,
  input logic                  mem_req_valid,
  input logic                  mem_req_ready,
  input logic                  mem_req_write,
  input logic [BLK_W-1:0]      mem_req_blk,
  input logic [LINE_W-1:0]     mem_req_wdata,
  input logic                  mem_rsp_valid,
  input logic [VB_ENTRIES-1:0] vb_match
);
  logic cpu_pend, rd_open;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cpu_pend <= 1'b0;
      rd_open  <= 1'b0;
    end else begin
      if (cpu_req_valid && cpu_req_ready) cpu_pend <= 1'b1;
      else if (cpu_rsp_valid)             cpu_pend <= 1'b0;
      if (mem_req_valid && mem_req_ready && !mem_req_write) rd_open <= 1'b1;
      else if (mem_rsp_valid)                               rd_open <= 1'b0;
    end
  end

  // R9
  busy_not_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_pend |-> !cpu_req_ready);
  // R3
  rsp_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rsp_valid |-> cpu_pend);
  // R9
  mem_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_blk)
      && $stable(mem_req_write) && $stable(mem_req_wdata)));
  // R7
  one_mem_txn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_open |-> !mem_req_valid);
  // R6
  no_dup_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(vb_match));
endmodule

bind vc_cache vc_cache_chk #(.BLK_W(BLK_W), .LINE_W(LINE_W), .VB_ENTRIES(VB_ENTRIES)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req_valid(cpu_req_valid),
  .cpu_req_ready(cpu_req_ready), .cpu_rsp_valid(cpu_rsp_valid),
  .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
  .mem_req_write(mem_req_write), .mem_req_blk(mem_req_blk),
  .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
  .vb_match(vb_match)
);

// File: tb/vc_cache_tb.sv
module vc_cache_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cpu_req_valid = 1'b0, cpu_req_write = 1'b0;
  logic [23:0] cpu_req_addr = '0;
  logic [7:0]  cpu_req_wdata = '0;
  logic        cpu_req_ready, cpu_rsp_valid;
  logic [7:0]  cpu_rsp_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0, mem_rsp_valid = 1'b0;
  logic [21:0] mem_req_blk;
  logic [31:0] mem_req_wdata;
  logic [31:0] mem_rsp_rdata = '0;

  always #5 clk = ~clk;

  vc_cache u_dut (
    .clk(clk), .rst_n(rst_n),
    .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
    .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
    .cpu_req_wdata(cpu_req_wdata), .cpu_rsp_valid(cpu_rsp_valid),
    .cpu_rsp_rdata(cpu_rsp_rdata), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_blk(mem_req_blk), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  int checks = 0, errors = 0;
  int n_reads = 0, n_writes = 0;
  logic [21:0] last_wblk = '0;
  logic [31:0] img [int];
  logic [31:0] store [int];
  logic [7:0]  exp_q [$];
  string       tag_q [$];

  function automatic logic [31:0] pat(int b);
    return (32'(b) * 32'h9E3779B1) ^ 32'hC0DE_1234;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // memory model: one cycle to accept, response two negedges later
  initial begin
    int pend = 0;
    forever begin
      @(negedge clk);
      mem_req_ready = 1'b0;
      mem_rsp_valid = 1'b0;
      if (pend > 0) begin
        pend--;
        if (pend == 0) mem_rsp_valid = 1'b1;
      end else if (rst_n && mem_req_valid) begin
        mem_req_ready = 1'b1;
        if (mem_req_write) begin
          store[int'(mem_req_blk)] = mem_req_wdata;
          last_wblk = mem_req_blk;
          n_writes++;
        end else begin
          mem_rsp_rdata = store.exists(int'(mem_req_blk)) ?
                          store[int'(mem_req_blk)] : pat(int'(mem_req_blk));
          n_reads++;
          pend = 2;
        end
      end
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && cpu_rsp_valid) begin
      if (exp_q.size() == 0) check(1'b0, "R3 unexpected response", 32'(cpu_rsp_rdata), 0);
      else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(cpu_rsp_rdata == e, t, 32'(cpu_rsp_rdata), 32'(e));
      end
    end
  end

  task automatic do_op(bit wr, logic [23:0] a, logic [7:0] d, string t);
    int b = int'(a[23:2]);
    logic [31:0] cur;
    cur = img.exists(b) ? img[b] : pat(b);
    if (wr) begin
      cur[{a[1:0], 3'b000} +: 8] = d;
      img[b] = cur;
      exp_q.push_back(d);
    end else exp_q.push_back(cur[{a[1:0], 3'b000} +: 8]);
    tag_q.push_back(t);
    @(negedge clk);
    cpu_req_valid = 1'b1; cpu_req_write = wr; cpu_req_addr = a; cpu_req_wdata = d;
    while (!cpu_req_ready) @(negedge clk);
    @(posedge clk);
    @(negedge clk);
    cpu_req_valid = 1'b0;
    check(!cpu_req_ready, "R9 ready low while busy", 32'(cpu_req_ready), 0);
    while (exp_q.size() != 0) @(negedge clk);
  endtask

  localparam logic [23:0] A = 24'h000100, B = 24'h000200;

  initial begin
    repeat (100000) @(posedge clk);
    check(1'b0, "watchdog", 0, 1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int r0, w0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(cpu_req_ready == 1'b1, "R2 ready after reset", 32'(cpu_req_ready), 1);
    check(mem_req_valid == 1'b0, "R2 no memory request at reset", 32'(mem_req_valid), 0);
    rst_n = 1'b1;

    do_op(0, A, 0, "R5 read miss data");
    check(n_reads == 1, "R2 R5 first access fetches", n_reads, 1);
    do_op(0, A + 3, 0, "R1 lane 3 on hit");
    do_op(0, A + 1, 0, "R3 read hit");
    check(n_reads == 1, "R3 hit has no fetch", n_reads, 1);

    r0 = n_reads; w0 = n_writes;
    do_op(1, A + 2, 8'h5A, "R4 write hit response");
    do_op(0, A + 2, 0, "R4 written byte read back");
    do_op(0, A + 1, 0, "R4 neighbour byte unchanged");
    check(n_reads == r0 && n_writes == w0, "R4 write hit no memory traffic",
          n_reads + n_writes, r0 + w0);

    do_op(0, B, 0, "R5 conflicting miss");
    check(n_reads == 2, "R5 second fetch", n_reads, 2);
    for (int i = 0; i < 4; i++) begin
      do_op(0, A + 24'(i % 4), 0, "R6 swap back A");
      do_op(0, B + 24'(i % 4), 0, "R6 swap back B");
    end
    check(n_reads == 2, "R10 alternation costs two fetches", n_reads, 2);
    check(n_writes == 0, "R8 dirty line not written during swaps", n_writes, 0);

    // walk the victim pointer: A (dirty) sits in the oldest slot
    do_op(0, 24'h000300, 0, "R7 fill C");
    do_op(0, 24'h000400, 0, "R7 fill D");
    do_op(0, 24'h000500, 0, "R7 fill E");
    check(n_writes == 0, "R7 empty slots need no write", n_writes, 0);
    do_op(0, 24'h000600, 0, "R7 fill F");
    check(n_writes == 1, "R7 dirty oldest written back", n_writes, 1);
    check(last_wblk == A[23:2], "R7 write-back block number", 32'(last_wblk), 32'(A[23:2]));
    check(store[int'(A[23:2])] == img[int'(A[23:2])], "R8 write-back carries modified data",
          store[int'(A[23:2])], img[int'(A[23:2])]);
    do_op(0, 24'h000700, 0, "R7 fill G");
    check(n_writes == 1, "R7 clean displaced entry not written", n_writes, 1);
    r0 = n_reads;
    do_op(0, 24'h000400, 0, "R6 victim hit D");
    check(n_reads == r0, "R6 victim hit needs no fetch", n_reads, r0);
    do_op(0, A + 2, 0, "R8 refetch after write-back");
    check(n_reads == r0 + 1, "R7 evicted block refetched", n_reads, r0 + 1);

    do_op(1, 24'h000805, 8'hC3, "R5 write miss");
    do_op(0, 24'h000805, 0, "R1 R5 write miss byte lane 1");
    do_op(0, 24'h000104, 0, "R1 other index independent");

    repeat (4) @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule